// File: doc/BRIEF.md
# Single-Wire Bus ROM Search Step Unit

This block carries out one decision step of the ROM search on a single-wire bus. On a start strobe it asks an external slot generator for two read slots. The first read returns the identity bit of the devices still taking part in the search, and the second returns the complement of that bit. The block then chooses a branch direction. It either aborts, or it sends the chosen direction back onto the bus as a third write slot. The caller runs the full 64-step search loop and keeps track of discrepancies between passes. This unit only supplies the per-bit verdict.

The unit talks to the slot generator through a request/acknowledge pair. It holds `slot_req` high with the slot value on `slot_bit` until `slot_ack` pulses. On a read slot, `slot_bit` is 1 and the generator returns the sampled bus level on `slot_rd` in the acknowledge cycle. The verdict appears on a registered 3-bit `status` word together with a one-cycle `done` pulse.

Top module: `owsrch_step`

## Requirements
- R1: While reset is held, and on the first cycle after it, `status` is 3'b000 and `done`, `slot_req` and `busy` are all 0.
- R2: An accepted step issues its first two slots as read slots (`slot_bit` = 1). The level returned on the first is the identity bit and is reported in `status` bit 0. The level returned on the second is the complement bit and is reported in `status` bit 1.
- R3: When both returned levels are 1, the step ends after the second slot with `status` = 3'b011, and no third slot is requested.
- R4: When both returned levels are 0, the direction is `pref_dir` as sampled with the accepted start. A third slot writes that direction, and `status` is 3'b100 for direction 1 or 3'b000 for direction 0.
- R5: When exactly one returned level is 1, the direction equals the identity bit. A third slot writes it, and `status` is 3'b101 (identity 1) or 3'b010 (complement 1).
- R6: `done` pulses for exactly one cycle, on the cycle after the acknowledge of the last slot. `status` carries the new code in that same cycle and keeps it until the next accepted start, which clears it to 3'b000.
- R7: A start seen while `busy` is 1 is ignored: it does not change the direction used, the number of slots, or the verdict.
- R8: `slot_req` stays high and `slot_bit` stays stable until `slot_ack` is seen. `slot_req` falls on the cycle after the acknowledge, and at least one idle cycle separates consecutive slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a search step (taken only when idle) |
| pref_dir | input | 1 | Direction to take when both read levels are 0 |
| slot_ack | input | 1 | Slot generator finished the current slot |
| slot_rd | input | 1 | Bus level sampled in a read slot, valid with `slot_ack` |
| slot_req | output | 1 | Request for a bus slot |
| slot_bit | output | 1 | Value of the requested slot (1 = read / write-one) |
| status | output | 3 | Verdict: bit 0 identity, bit 1 complement, bit 2 direction |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | A step is in progress |

## Verification
The checker runs on every cycle and covers the slot handshake rules (request held until acknowledged, stable slot value, request dropped after acknowledge) and the single-cycle `done` pulse. It also checks that `status` changes only on completion or on an accepted start, and that every completed code is self-consistent: the error code has no direction bit, and a single 1 sets the direction from the identity bit. Other behaviour depends on what the bus returned and on the preference, and only the bench scenarios can show it. This covers the order of the two reads, the use of `pref_dir` for the 0/0 case, the missing third slot on 1/1, the value actually written in the direction slot, and the fact that a start arriving mid-step is ignored.

// File: rtl/owsrch_pkg.sv
package owsrch_pkg;

  localparam int CODE_W  = 3;
  localparam int IDX_ID  = 0;
  localparam int IDX_CMP = 1;
  localparam int IDX_DIR = 2;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RD_ID  = 2'd1,
    ST_RD_CMP = 2'd2,
    ST_WR_DIR = 2'd3
  } step_state_t;

  typedef struct packed {
    logic              dir;
    logic              err;
    logic [CODE_W-1:0] code;
  } verdict_t;

endpackage

// File: rtl/owsrch_decide.sv
module owsrch_decide
  import owsrch_pkg::*;
(
  input  logic     id_bit,
  input  logic     cmp_bit,
  input  logic     pref,
  output verdict_t verdict
);

  logic single_one;

  always_comb begin
    single_one       = id_bit ^ cmp_bit;
    verdict.err      = id_bit & cmp_bit;
    verdict.dir      = single_one ? id_bit : pref;
    verdict.code     = '0;
    if (verdict.err) begin
      verdict.code[IDX_ID]  = 1'b1;
      verdict.code[IDX_CMP] = 1'b1;
      verdict.dir           = 1'b0;
    end else begin
      verdict.code[IDX_ID]  = id_bit;
      verdict.code[IDX_CMP] = cmp_bit;
      verdict.code[IDX_DIR] = verdict.dir;
    end
  end

endmodule

// File: rtl/owsrch_slot.sv
module owsrch_slot (
  input  logic clk,
  input  logic rst,
  input  logic launch,
  input  logic launch_bit,
  input  logic ack,
  output logic req,
  output logic bit_o,
  output logic finished
);

  always_ff @(posedge clk) begin
    if (rst) begin
      req   <= 1'b0;
      bit_o <= 1'b1;
    end else if (launch) begin
      req   <= 1'b1;
      bit_o <= launch_bit;
    end else if (req && ack) begin
      req   <= 1'b0;
      bit_o <= 1'b1;
    end
  end

  assign finished = req & ack;

endmodule

// File: rtl/owsrch_fsm.sv
module owsrch_fsm
  import owsrch_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              pref_dir,
  input  logic              slot_fin,
  input  logic              slot_rd,
  input  verdict_t          verdict,
  output logic              id_q,
  output logic              pref_q,
  output logic              launch,
  output logic              launch_bit,
  output logic [CODE_W-1:0] status_q,
  output logic              done_q,
  output logic              busy_q
);

  step_state_t       state;
  logic              need_launch;
  logic              dir_q;
  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      need_launch <= 1'b0;
      id_q        <= 1'b0;
      pref_q      <= 1'b0;
      dir_q       <= 1'b0;
      code_q      <= '0;
      status_q    <= '0;
      done_q      <= 1'b0;
    end else begin
      done_q      <= 1'b0;
      need_launch <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            pref_q      <= pref_dir;
            status_q    <= '0;
            need_launch <= 1'b1;
            state       <= ST_RD_ID;
          end
        end
        ST_RD_ID: begin
          if (slot_fin) begin
            id_q        <= slot_rd;
            need_launch <= 1'b1;
            state       <= ST_RD_CMP;
          end
        end
        ST_RD_CMP: begin
          if (slot_fin) begin
            if (verdict.err) begin
              status_q <= verdict.code;
              done_q   <= 1'b1;
              state    <= ST_IDLE;
            end else begin
              dir_q       <= verdict.dir;
              code_q      <= verdict.code;
              need_launch <= 1'b1;
              state       <= ST_WR_DIR;
            end
          end
        end
        ST_WR_DIR: begin
          if (slot_fin) begin
            status_q <= code_q;
            done_q   <= 1'b1;
            state    <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign launch     = need_launch;
  assign launch_bit = (state == ST_WR_DIR) ? dir_q : 1'b1;
  assign busy_q     = (state != ST_IDLE);

endmodule

// File: rtl/owsrch_step.sv
module owsrch_step
  import owsrch_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              pref_dir,
  input  logic              slot_ack,
  input  logic              slot_rd,
  output logic              slot_req,
  output logic              slot_bit,
  output logic [CODE_W-1:0] status,
  output logic              done,
  output logic              busy
);

  verdict_t verdict;
  logic     id_q;
  logic     pref_q;
  logic     launch;
  logic     launch_bit;
  logic     slot_fin;

  owsrch_decide u_decide (
    .id_bit  (id_q),
    .cmp_bit (slot_rd),
    .pref    (pref_q),
    .verdict (verdict)
  );

  owsrch_slot u_slot (
    .clk        (clk),
    .rst        (rst),
    .launch     (launch),
    .launch_bit (launch_bit),
    .ack        (slot_ack),
    .req        (slot_req),
    .bit_o      (slot_bit),
    .finished   (slot_fin)
  );

  owsrch_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .pref_dir   (pref_dir),
    .slot_fin   (slot_fin),
    .slot_rd    (slot_rd),
    .verdict    (verdict),
    .id_q       (id_q),
    .pref_q     (pref_q),
    .launch     (launch),
    .launch_bit (launch_bit),
    .status_q   (status),
    .done_q     (done),
    .busy_q     (busy)
  );

endmodule

// File: rtl/owsrch_step_chk.sv
module owsrch_step_chk (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       slot_ack,
  input logic       slot_req,
  input logic       slot_bit,
  input logic [2:0] status,
  input logic       done,
  input logic       busy
);

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (slot_req && !slot_ack) |=> slot_req);

  // R8
  slot_bit_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (slot_req && !slot_ack) |=> $stable(slot_bit));

  // R8
  req_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (slot_req && slot_ack) |=> !slot_req);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6
  status_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(status) |-> (done || $past(start && !busy)));

  // R3
  err_code_chk: assert property (@(posedge clk) disable iff (rst)
    (done && status[1:0] == 2'b11) |-> !status[2]);

  // R5
  id_one_chk: assert property (@(posedge clk) disable iff (rst)
    (done && status[1:0] == 2'b01) |-> status[2]);

  // R5
  cmp_one_chk: assert property (@(posedge clk) disable iff (rst)
    (done && status[1:0] == 2'b10) |-> !status[2]);

endmodule

bind owsrch_step owsrch_step_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .slot_ack (slot_ack),
  .slot_req (slot_req),
  .slot_bit (slot_bit),
  .status   (status),
  .done     (done),
  .busy     (busy)
);

// File: tb/owsrch_step_test.sv
module owsrch_step_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       pref_dir = 1'b0;
  logic       slot_ack = 1'b0;
  logic       slot_rd = 1'b0;
  logic       slot_req;
  logic       slot_bit;
  logic [2:0] status;
  logic       done;
  logic       busy;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  typedef struct {
    logic [2:0] st;
    int         nslots;
    logic [2:0] bits;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  logic resp_q[$];
  logic obs_q[$];

  always #2 clk = ~clk;

  owsrch_step uut (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .pref_dir (pref_dir),
    .slot_ack (slot_ack),
    .slot_rd  (slot_rd),
    .slot_req (slot_req),
    .slot_bit (slot_bit),
    .status   (status),
    .done     (done),
    .busy     (busy)
  );

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // Slot generator model: answers each request after two cycles
  initial begin
    int wcnt = 0;
    forever begin
      @(posedge clk);
      #1;
      if (slot_ack) begin
        slot_ack = 1'b0;
      end else if (slot_req) begin
        wcnt++;
        if (wcnt == 2) begin
          wcnt = 0;
          obs_q.push_back(slot_bit);
          slot_rd  = (resp_q.size() != 0) ? resp_q.pop_front() : 1'b1;
          slot_ack = 1'b1;
        end
      end
    end
  end

  // Monitor: compares each completed step against the scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (done) begin
        exp_t e;
        if (exp_q.size() == 0) begin
          check(1'b0, "R6 unexpected done", 1, 0);
        end else begin
          e = exp_q.pop_front();
          check(status == e.st, {e.tag, " status"}, int'(status), int'(e.st));
          check(obs_q.size() == e.nslots, {e.tag, " slot count"}, obs_q.size(), e.nslots);
          for (int k = 0; k < e.nslots && k < obs_q.size(); k++)
            check(obs_q[k] == e.bits[k], {e.tag, " slot value"}, int'(obs_q[k]), int'(e.bits[k]));
        end
        obs_q.delete();
      end
    end
  end

  task automatic run_step(input logic idb, input logic cmpb, input logic pref,
                          input string tag, input bit poke);
    exp_t e;
    logic dir;
    resp_q.push_back(idb);
    resp_q.push_back(cmpb);
    e.tag = tag;
    if (idb && cmpb) begin
      e.st = 3'b011; e.nslots = 2; e.bits = 3'b011;
    end else begin
      dir = (idb ^ cmpb) ? idb : pref;
      e.st = {dir, cmpb, idb};
      e.nslots = 3;
      e.bits = {dir, 2'b11};
    end
    exp_q.push_back(e);
    start = 1'b1; pref_dir = pref;
    @(posedge clk); #1;
    start = 1'b0; pref_dir = ~pref;
    // R6 status cleared by accepted start
    check(status == 3'b000, "R6 clear on start", int'(status), 0);
    check(busy == 1'b1, "R7 busy after start", int'(busy), 1);
    if (poke) begin
      // R7 start while busy, with the opposite preference
      repeat (2) @(posedge clk);
      #1 start = 1'b1; pref_dir = ~pref;
      @(posedge clk); #1 start = 1'b0;
      @(posedge clk); #1 start = 1'b1;
      @(posedge clk); #1 start = 1'b0;
    end
    while (exp_q.size() != 0) @(posedge clk);
    #2;
    repeat (4) @(posedge clk);
    #1;
    // R6 status held after completion
    check(status == e.st, {tag, " R6 hold"}, int'(status), int'(e.st));
    if (poke) begin
      check(slot_req == 1'b0 && obs_q.size() == 0, "R7 no extra slot", int'(slot_req), 0);
      check(busy == 1'b0, "R7 idle after step", int'(busy), 0);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset values
    check(status == 3'b000, "R1 status", int'(status), 0);
    check(done == 1'b0 && slot_req == 1'b0 && busy == 1'b0, "R1 controls",
          int'({done, slot_req, busy}), 0);
    rst = 1'b0;
    @(posedge clk); #1;
    check(status == 3'b000 && !done && !slot_req && !busy, "R1 after release",
          int'({status, done, slot_req, busy}), 0);

    run_step(1'b1, 1'b1, 1'b0, "R3 both ones", 1'b0);
    run_step(1'b0, 1'b0, 1'b1, "R4 zeros pref1", 1'b0);
    run_step(1'b0, 1'b0, 1'b0, "R4 zeros pref0", 1'b0);
    run_step(1'b1, 1'b0, 1'b0, "R5 id one", 1'b0);
    run_step(1'b0, 1'b1, 1'b1, "R5 cmp one", 1'b0);
    run_step(1'b1, 1'b0, 1'b1, "R2 id order", 1'b0);
    run_step(1'b0, 1'b1, 1'b0, "R2 cmp order", 1'b0);
    run_step(1'b1, 1'b1, 1'b1, "R3 both ones pref1", 1'b0);
    run_step(1'b0, 1'b0, 1'b1, "R7 poke pref1", 1'b1);
    run_step(1'b0, 1'b0, 1'b0, "R7 poke pref0", 1'b1);

    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule